// File: doc/BRIEF.md
# Banked GPIO Register Controller

This block is the register side of a general-purpose I/O unit with 128 pins, grouped as four banks of 32. Pin n sits in bank n>>5 at bit n&31. Software reaches it over a plain register bus with an address, a write strobe, write data, a read strobe and registered read data. Each bank holds a direction word, an output latch and two alternate-function words. The alternate-function words are storage only.

The output latch has no direct write path. Bits are raised through a set register and dropped through a clear register, so software never needs a read-modify-write cycle. Each pad is driven with the latch gated by its direction bit. The level register reads back a per-pin mix of driven and sampled values. A read of any level register produces a notify pulse for logic that wants to know when software polled the pins. A per-pin change strobe marks every cycle in which a driven value moves.

Offsets for the edge-detect registers are owned by a companion block. Here they answer quietly with zero.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, every direction, latch and alternate-function word is zero, so every pin is an input and pad_out, pad_change, bus_rdata, bus_err and lvl_read_pulse are all 0.
- R2: A write to a set register ORs the data into that bank's latch. Set offsets are 0x018, 0x01C and 0x020 for banks 0 to 2, and 0x118 for bank 3.
- R3: A write to a clear register clears the latch bits where the data has ones. Clear offsets are 0x024, 0x028 and 0x02C for banks 0 to 2, and 0x124 for bank 3.
- R4: pad_out bit n equals latch bit n AND direction bit n, where 1 means output. Direction offsets are 0x00C, 0x010 and 0x014 for banks 0 to 2, and 0x10C for bank 3.
- R5: A level read returns the latch bit for output pins and the pin_in bit for input pins. Level offsets are 0x000, 0x004 and 0x008 for banks 0 to 2, and 0x100 for bank 3.
- R6: Direction and alternate-function words read back what was written. Bank b has its low word at 0x054+8b and its high word at 0x058+8b.
- R7: A read of a set or clear register returns zero and raises bus_err together with that data.
- R8: lvl_read_pulse is high for exactly the one cycle in which a level read's data is presented, and it stays low for every other read.
- R9: A pad_change bit is high for exactly the one cycle in which the matching pad_out bit first shows a new value.
- R10: At offsets 0x200 and above, writes change nothing, reads return zero and bus_err stays low. Addresses there do not alias into the window below.
- R11: Any other offset below 0x200 not listed here, including misaligned ones, reads as zero and ignores writes. Any read or write there raises bus_err.
- R12: The edge-control offsets (0x030, 0x034, 0x038, 0x130; 0x03C, 0x040, 0x044, 0x13C; 0x048, 0x04C, 0x050, 0x148) read zero without bus_err, and writes to them change no state in this block.
- R13: Read data, bus_err and lvl_read_pulse appear in the cycle after the read strobe is sampled, and bus_rdata is zero in cycles that follow no read. A write takes effect at the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, one cycle after bus_rd |
| bus_err | output | 1 | Access-error flag, aligned with read data |
| lvl_read_pulse | output | 1 | One-cycle pulse when a level register is read |
| pin_in | input | 128 | Sampled pad input levels |
| pad_out | output | 128 | Driven pad values |
| pad_change | output | 128 | Per-pin strobe when a driven value changes |

## Verification
The latch is driven with overlapping set and clear masks while direction is held fixed, which separates OR and AND-NOT behaviour from a plain overwrite. Direction is then changed while the latch is held fixed. This shows that pad_out and the change strobe follow the gating and not only the latch. Level reads use a pin_in pattern that differs from the latch in every nibble, so swapping or dropping the direction mux shows up at once. Address probes cover bank 3's upper page and the alternate-function pairs. They also cover the gaps, misaligned offsets, the edge-control offsets and aliases above 0x200, which separates quiet zero reads from error reads.

// File: rtl/gpio_pkg.sv
// Shared sizes and decode types for the banked GPIO controller.
// Assumes the register window spans 2**OFF_W bytes of word registers.
package gpio_pkg;
    parameter int NBANKS = 4;
    parameter int BANK_W = 32;
    parameter int ADDR_W = 12;
    parameter int OFF_W  = 9;
    localparam int BIDX_W = $clog2(NBANKS);
    localparam int NPINS  = NBANKS * BANK_W;

    typedef enum logic [3:0] {
        K_NONE,
        K_LVL,
        K_DIR,
        K_SET,
        K_CLR,
        K_EDGE,
        K_AFL,
        K_AFH,
        K_OUTSIDE
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e         kind;
        logic [BIDX_W-1:0] bank;
    } reg_sel_t;
endpackage

// File: rtl/gpio_addr_dec.sv
// Maps a byte offset onto a register kind and bank.
// Assumes the lower page holds three banks per group, spaced by a word,
// and the upper page (offset bit 8) holds the last bank of each group.
module gpio_addr_dec
    import gpio_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);
    localparam int GRP_STRIDE = NBANKS - 1;
    localparam int N_GRPWORDS = 7 * GRP_STRIDE;
    localparam int N_AFWORDS  = 2 * NBANKS;

    int unsigned wi;
    int unsigned grp;
    int unsigned afi;

    // Decode the offset into kind and bank.
    always_comb begin
        sel.kind = K_NONE;
        sel.bank = '0;
        wi       = {26'd0, addr[7:2]};
        grp      = wi / GRP_STRIDE;
        afi      = wi - N_GRPWORDS;
        if (addr >= ADDR_W'(1 << OFF_W)) begin
            sel.kind = K_OUTSIDE;
        end else if (addr[1:0] != 2'b00) begin
            sel.kind = K_NONE;
        end else if (!addr[8]) begin
            if (wi < N_GRPWORDS) begin
                sel.bank = BIDX_W'(wi % GRP_STRIDE);
                case (grp)
                    0:       sel.kind = K_LVL;
                    1:       sel.kind = K_DIR;
                    2:       sel.kind = K_SET;
                    3:       sel.kind = K_CLR;
                    default: sel.kind = K_EDGE;
                endcase
            end else if (wi < N_GRPWORDS + N_AFWORDS) begin
                sel.bank = BIDX_W'(afi >> 1);
                sel.kind = afi[0] ? K_AFH : K_AFL;
            end
        end else if (wi < N_GRPWORDS && (wi % GRP_STRIDE) == 0) begin
            sel.bank = BIDX_W'(NBANKS - 1);
            case (grp)
                0:       sel.kind = K_LVL;
                1:       sel.kind = K_DIR;
                2:       sel.kind = K_SET;
                3:       sel.kind = K_CLR;
                default: sel.kind = K_EDGE;
            endcase
        end
    end
endmodule

// File: rtl/gpio_bank.sv
// State of one 32-pin bank: direction, set/clear latch, alternate words,
// and the drive, change and level views derived from them.
// Assumes at most one write enable is high in a cycle.
module gpio_bank
    import gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_dir,
    input  logic              wr_set,
    input  logic              wr_clr,
    input  logic              wr_afl,
    input  logic              wr_afh,
    input  logic [BANK_W-1:0] wdata,
    input  logic [BANK_W-1:0] pins,
    output logic [BANK_W-1:0] dir_q,
    output logic [BANK_W-1:0] afl_q,
    output logic [BANK_W-1:0] afh_q,
    output logic [BANK_W-1:0] drive,
    output logic [BANK_W-1:0] change,
    output logic [BANK_W-1:0] level
);
    logic [BANK_W-1:0] latch_q;
    logic [BANK_W-1:0] prev_q;

    // Direction and alternate-function storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '0;
            afl_q <= '0;
            afh_q <= '0;
        end else begin
            if (wr_dir) dir_q <= wdata;
            if (wr_afl) afl_q <= wdata;
            if (wr_afh) afh_q <= wdata;
        end
    end

    // Output latch, changed only through set and clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      latch_q <= '0;
        else if (wr_set) latch_q <= latch_q | wdata;
        else if (wr_clr) latch_q <= latch_q & ~wdata;
    end

    // Hold last cycle's driven value for the change strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= drive;
    end

    // Derived pad views.
    always_comb begin
        drive  = latch_q & dir_q;
        change = drive ^ prev_q;
        level  = drive | (pins & ~dir_q);
    end
endmodule

// File: rtl/gpio_read_mux.sv
// Selects the read word for a decoded register and classifies the read.
// Assumes sel.bank is in range whenever kind names a bank register.
module gpio_read_mux
    import gpio_pkg::*;
(
    input  reg_sel_t                       sel,
    input  logic [NBANKS-1:0][BANK_W-1:0]  level_a,
    input  logic [NBANKS-1:0][BANK_W-1:0]  dir_a,
    input  logic [NBANKS-1:0][BANK_W-1:0]  afl_a,
    input  logic [NBANKS-1:0][BANK_W-1:0]  afh_a,
    output logic [BANK_W-1:0]              word,
    output logic                           bad,
    output logic                           is_lvl
);
    // Pick the word and flag error reads.
    always_comb begin
        word   = '0;
        bad    = 1'b0;
        is_lvl = 1'b0;
        case (sel.kind)
            K_LVL: begin
                word   = level_a[sel.bank];
                is_lvl = 1'b1;
            end
            K_DIR:               word = dir_a[sel.bank];
            K_AFL:               word = afl_a[sel.bank];
            K_AFH:               word = afh_a[sel.bank];
            K_SET, K_CLR, K_NONE: bad = 1'b1;
            default:             word = '0;
        endcase
    end
endmodule

// File: rtl/gpio_bank_ctrl.sv
// Banked GPIO register controller top: decodes bus accesses, holds the
// per-bank state and registers read data, error and level-read notify.
// Assumes bus strobes are synchronous to clk; reads have one cycle latency.
module gpio_bank_ctrl
    import gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [11:0]       bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    output logic              bus_err,
    output logic              lvl_read_pulse,
    input  logic [127:0]      pin_in,
    output logic [127:0]      pad_out,
    output logic [127:0]      pad_change
);
    reg_sel_t                      sel;
    logic [NBANKS-1:0][BANK_W-1:0] level_a, dir_a, afl_a, afh_a;
    logic [BANK_W-1:0]             rd_word;
    logic                          rd_bad, rd_lvl;

    gpio_addr_dec u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        logic [BANK_W-1:0] drive_b, change_b;
        logic              hit;
        assign hit = bus_wr && (sel.bank == BIDX_W'(b));

        gpio_bank u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_dir (hit && sel.kind == K_DIR),
            .wr_set (hit && sel.kind == K_SET),
            .wr_clr (hit && sel.kind == K_CLR),
            .wr_afl (hit && sel.kind == K_AFL),
            .wr_afh (hit && sel.kind == K_AFH),
            .wdata  (bus_wdata),
            .pins   (pin_in[b*BANK_W +: BANK_W]),
            .dir_q  (dir_a[b]),
            .afl_q  (afl_a[b]),
            .afh_q  (afh_a[b]),
            .drive  (drive_b),
            .change (change_b),
            .level  (level_a[b])
        );

        assign pad_out[b*BANK_W +: BANK_W]    = drive_b;
        assign pad_change[b*BANK_W +: BANK_W] = change_b;
    end

    gpio_read_mux u_rmux (
        .sel     (sel),
        .level_a (level_a),
        .dir_a   (dir_a),
        .afl_a   (afl_a),
        .afh_a   (afh_a),
        .word    (rd_word),
        .bad     (rd_bad),
        .is_lvl  (rd_lvl)
    );

    // Register read data, access error and level-read notify.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata      <= '0;
            bus_err        <= 1'b0;
            lvl_read_pulse <= 1'b0;
        end else begin
            bus_rdata      <= bus_rd ? rd_word : '0;
            bus_err        <= (bus_rd && rd_bad) || (bus_wr && sel.kind == K_NONE);
            lvl_read_pulse <= bus_rd && rd_lvl;
        end
    end
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
// Port-level properties for gpio_bank_ctrl, attached by bind.
// Assumes the default 12-bit address and 128-pin configuration.
module gpio_bank_ctrl_chk (
    input logic         clk,
    input logic         rst_n,
    input logic [11:0]  bus_addr,
    input logic         bus_wr,
    input logic [31:0]  bus_wdata,
    input logic         bus_rd,
    input logic [31:0]  bus_rdata,
    input logic         bus_err,
    input logic         lvl_read_pulse,
    input logic [127:0] pad_out,
    input logic [127:0] pad_change
);
    // R1: reset clears outputs.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (pad_out == '0 && bus_rdata == '0 && !bus_err && !lvl_read_pulse));

    // R9: change strobe marks exactly the pad bits that just moved.
    a_r9_change_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> pad_change == (pad_out ^ $past(pad_out)));

    // R3: clearing all of bank 0 drops its pads.
    a_r3_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 12'h024 && bus_wdata == 32'hFFFF_FFFF) |=> pad_out[31:0] == '0);

    // R7: read of a set register gives zero with error.
    a_r7_set_read_err: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 12'h018) |=> (bus_err && bus_rdata == '0));

    // R10: outside the window, zero and no error.
    a_r10_outside_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr >= 12'h200) |=> (bus_rdata == '0 && !bus_err));

    // R8: notify only follows a read strobe.
    a_r8_notify_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_read_pulse |-> $past(bus_rd));

    // R13: error only follows an access.
    a_r13_err_after_access: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_rd || bus_wr));
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_addr       (bus_addr),
    .bus_wr         (bus_wr),
    .bus_wdata      (bus_wdata),
    .bus_rd         (bus_rd),
    .bus_rdata      (bus_rdata),
    .bus_err        (bus_err),
    .lvl_read_pulse (lvl_read_pulse),
    .pad_out        (pad_out),
    .pad_change     (pad_change)
);

// File: tb/gpio_bank_ctrl_test.sv
`timescale 1ns/1ps
module gpio_bank_ctrl_test;
    logic         clk = 0;
    logic         rst_n = 0;
    logic [11:0]  bus_addr = '0;
    logic         bus_wr = 0;
    logic [31:0]  bus_wdata = '0;
    logic         bus_rd = 0;
    logic [31:0]  bus_rdata;
    logic         bus_err;
    logic         lvl_read_pulse;
    logic [127:0] pin_in = '0;
    logic [127:0] pad_out;
    logic [127:0] pad_change;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        logic [31:0] data;
        logic        err;
        logic        ntf;
        string       tag;
    } exp_t;
    exp_t sb[$];
    logic rd_q = 0;

    logic [31:0] m_dir [4];
    logic [31:0] m_lat [4];

    gpio_bank_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .lvl_read_pulse(lvl_read_pulse), .pin_in(pin_in),
        .pad_out(pad_out), .pad_change(pad_change)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int grp_off(input int base, input int b);
        return (b < 3) ? base + 4 * b : base + 'h100;
    endfunction

    function automatic logic [127:0] exp_pads();
        logic [127:0] v;
        for (int b = 0; b < 4; b++) v[b*32 +: 32] = m_lat[b] & m_dir[b];
        return v;
    endfunction

    // Monitor: compare each read result against the scoreboard.
    always @(posedge clk) rd_q <= bus_rd && rst_n;
    always @(negedge clk) begin
        if (rd_q) begin
            exp_t e;
            if (sb.size() == 0) begin
                chk(0, "scoreboard empty", 0, 0);
            end else begin
                e = sb.pop_front();
                chk(bus_rdata == e.data, e.tag, bus_rdata, e.data);
                chk(bus_err == e.err, {e.tag, " err"}, bus_err, e.err);
                chk(lvl_read_pulse == e.ntf, {e.tag, " notify"}, lvl_read_pulse, e.ntf);
            end
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = 12'(a); bus_wdata = d; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input int a, input logic [31:0] d, input logic e, input logic n, input string tag);
        exp_t x;
        x.data = d; x.err = e; x.ntf = n; x.tag = tag;
        @(negedge clk);
        sb.push_back(x);
        bus_addr = 12'(a); bus_rd = 1;
        @(negedge clk);
        bus_rd = 0;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int b = 0; b < 4; b++) begin m_dir[b] = 0; m_lat[b] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk(pad_out == 0, "R1 pad_out", pad_out, 0);
        chk(pad_change == 0, "R1 pad_change", pad_change, 0);
        chk(bus_rdata == 0 && !bus_err && !lvl_read_pulse, "R1 bus outputs", bus_rdata, 0);
        for (int b = 0; b < 4; b++) rd(grp_off('h00C, b), 0, 0, 0, "R1 dir reset");

        // R4 / R2: direction then set on bank 0
        wr('h00C, 32'hFFFF_0000); m_dir[0] = 32'hFFFF_0000;
        chk(pad_out == 0, "R4 no latch no drive", pad_out, 0);
        wr('h018, 32'h00FF_00FF); m_lat[0] = 32'h00FF_00FF;
        chk(pad_out == exp_pads(), "R2 set bank0", pad_out, exp_pads());
        chk(pad_change[31:0] == 32'h00FF_0000, "R9 change pulse", pad_change[31:0], 32'h00FF_0000);
        @(negedge clk);
        chk(pad_change == 0, "R9 pulse one cycle", pad_change, 0);
        wr('h018, 32'h0F00_0000); m_lat[0] |= 32'h0F00_0000;
        chk(pad_out == exp_pads(), "R2 set ORs", pad_out, exp_pads());

        // R3: clear
        wr('h024, 32'h000F_0000); m_lat[0] &= ~32'h000F_0000;
        chk(pad_out == exp_pads(), "R3 clear bank0", pad_out, exp_pads());

        // R5 / R8: level read with mixed directions
        pin_in[31:0] = 32'hA5A5_A5A5;
        rd('h000, (m_lat[0] & m_dir[0]) | (32'hA5A5_A5A5 & ~m_dir[0]), 0, 1, "R5 R8 level bank0");
        // R13: read data returns to zero after its cycle
        @(negedge clk);
        chk(bus_rdata == 0 && !lvl_read_pulse, "R13 rdata idle", bus_rdata, 0);

        // Bank 3 on the upper page
        wr('h118, 32'h1234_5678); m_lat[3] = 32'h1234_5678;
        chk(pad_out == exp_pads(), "R4 latch without dir", pad_out, exp_pads());
        wr('h10C, 32'hFFFF_FFFF); m_dir[3] = 32'hFFFF_FFFF;
        chk(pad_out[127:96] == 32'h1234_5678, "R4 dir enables drive", pad_out[127:96], 32'h1234_5678);
        chk(pad_change[127:96] == 32'h1234_5678, "R9 change on dir", pad_change[127:96], 32'h1234_5678);
        wr('h124, 32'h0000_FFFF); m_lat[3] &= 32'hFFFF_0000;
        chk(pad_out == exp_pads(), "R3 clear bank3", pad_out, exp_pads());
        pin_in[127:96] = 32'hFFFF_FFFF;
        rd('h100, m_lat[3], 0, 1, "R5 level bank3 all out");

        // Bank 1 and 2 direction readback and level with all inputs
        wr('h010, 32'hDEAD_BEEF); m_dir[1] = 32'hDEAD_BEEF;
        rd('h010, 32'hDEAD_BEEF, 0, 0, "R6 dir bank1");
        pin_in[95:64] = 32'h3C3C_3C3C;
        rd('h008, 32'h3C3C_3C3C, 0, 1, "R5 level bank2 inputs");

        // R6: alternate-function words
        for (int b = 0; b < 4; b++) begin
            wr('h054 + 8*b, 32'h1100_0000 + b);
            wr('h058 + 8*b, 32'h2200_0000 + b);
        end
        for (int b = 0; b < 4; b++) begin
            rd('h054 + 8*b, 32'h1100_0000 + b, 0, 0, "R6 af low");
            rd('h058 + 8*b, 32'h2200_0000 + b, 0, 0, "R6 af high");
        end
        chk(pad_out == exp_pads(), "R6 af no drive effect", pad_out, exp_pads());

        // R7: write-only registers
        rd('h018, 0, 1, 0, "R7 set read");
        rd('h01C, 0, 1, 0, "R7 set read bank1");
        rd('h124, 0, 1, 0, "R7 clear read bank3");

        // R10: outside the window
        wr('h20C, 32'h0000_0000);
        chk(!bus_err, "R10 write err", bus_err, 0);
        rd('h00C, m_dir[0], 0, 0, "R10 no alias dir");
        wr('h218, 32'hFFFF_FFFF);
        chk(pad_out == exp_pads(), "R10 no alias set", pad_out, exp_pads());
        rd('h200, 0, 0, 0, "R10 read outside");
        rd('hFFC, 0, 0, 0, "R10 read top");

        // R11: unmapped and misaligned
        rd('h074, 0, 1, 0, "R11 gap read");
        rd('h104, 0, 1, 0, "R11 upper gap read");
        rd('h002, 0, 1, 0, "R11 misaligned read");
        wr('h0FC, 32'hFFFF_FFFF);
        chk(bus_err, "R11 write err", bus_err, 1);
        wr('h00E, 32'h0000_0000);
        rd('h00C, m_dir[0], 0, 0, "R11 misaligned write ignored");
        wr('h01A, 32'hFFFF_FFFF);
        chk(pad_out == exp_pads(), "R11 misaligned set ignored", pad_out, exp_pads());

        // R12: edge-control offsets
        wr('h030, 32'hFFFF_FFFF);
        chk(!bus_err && pad_out == exp_pads(), "R12 edge write", pad_out, exp_pads());
        rd('h030, 0, 0, 0, "R12 rise read");
        rd('h13C, 0, 0, 0, "R12 fall read");
        rd('h148, 0, 0, 0, "R12 status read");

        // R13: write then read back in the next cycle
        @(negedge clk);
        bus_addr = 12'h014; bus_wdata = 32'h0000_00F0; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0;
        m_dir[2] = 32'h0000_00F0;
        rd('h014, 32'h0000_00F0, 0, 0, "R13 write visible next read");

        repeat (3) @(negedge clk);
        chk(sb.size() == 0, "scoreboard drained", sb.size(), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule